// File: doc/BRIEF.md
# Byte-Lane Enable Write Sequencer

This adapter sits between a register-write requester and an interconnect that cannot infer byte lanes from a write's size. For every accepted write of one byte, two bytes or a full 32-bit word, it first sends a sideband control write that carries a four-bit lane-enable nibble, and then sends the data write itself. The two downstream writes form one indivisible pair. Nothing else is accepted until the data write has been acknowledged, so no other write can land between them.

The lane nibble sits at bits [6:3] of the control word. The requester puts its bytes on the lanes where they belong, and the data write passes address and data through unchanged. After reset the block issues one control write that enables all four lanes before it accepts any request. A halfword that would straddle the word boundary, or the reserved size code, is refused with a one-cycle error pulse and produces no downstream traffic.

Top module: `lbw_write_sequencer`

## Requirements
- R1: On leaving reset, the block presents a control write of value 0x78 (all four lanes enabled) with `req_ready` low, and accepts no request until that control write is acknowledged.
- R2: Every control write carries the lane nibble at bits [6:3], and all other bits of the control word are zero.
- R3: A byte write (size code 0) enables exactly lane `1 << addr[1:0]`.
- R4: A halfword write (size code 1) at offset `addr[1:0]` of 0, 1 or 2 enables lanes `2'b11 << addr[1:0]`.
- R5: A word write (size code 2) enables all four lanes (nibble 4'hF).
- R6: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. The control write is presented the cycle after acceptance. The data write is presented the cycle after the control write is acknowledged, and never while a control write is presented.
- R7: `req_ready` is low from acceptance until the data write is acknowledged, and is high again in the following cycle.
- R8: A halfword at offset 3, or size code 3, raises `req_err` for exactly the cycle after acceptance. It issues no control or data write, and `req_ready` stays high.
- R9: A presented control or data write keeps its valid and its payload unchanged until it is acknowledged.
- R10: The data write carries the accepted address, size and data unchanged, so that a byte-enabled target that uses the last control nibble stores exactly the enabled bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Upstream write request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_data | input | DATA_W | Lane-aligned write data |
| req_err | output | 1 | One-cycle pulse for a refused request |
| ctl_valid | output | 1 | Control write presented |
| ctl_data | output | CTL_W | Control word, lane nibble at [6:3] |
| ctl_ack | input | 1 | Control write accepted downstream |
| wr_valid | output | 1 | Data write presented |
| wr_addr | output | ADDR_W | Data write address |
| wr_size | output | 2 | Data write size code |
| wr_data | output | DATA_W | Data write payload |
| wr_ack | input | 1 | Data write accepted downstream |

## Verification
The assertions assume that `ctl_ack` is high only while `ctl_valid` is high, and `wr_ack` only while `wr_valid` is high. They also assume that the requester keeps a raised `req_valid` and its payload steady until it sees `req_ready`. The bench raises each acknowledge only in cycles where its own model expects that write to be presented, with pseudo-random delays. It presents each request once and holds it until acceptance. Directed requests at every offset and size, including both refused forms, come before a random mix.

// File: rtl/lbw_pkg.sv
// Shared types for the byte-lane write sequencer.
// Assumes a size code of two bits; code 3 is reserved and refused.
package lbw_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        PH_BOOT = 2'd0,
        PH_IDLE = 2'd1,
        PH_CTL  = 2'd2,
        PH_DATA = 2'd3
    } phase_e;
endpackage

// File: rtl/lbw_lane_decode.sv
// Turns a size code and the low address bits into a lane-enable mask.
// Assumes lanes are byte wide and numbered from the least significant byte.
// It flags a halfword in the top lane and the reserved size as illegal.
module lbw_lane_decode
    import lbw_pkg::*;
#(
    parameter int LANES = 4,
    parameter int OFS_W = $clog2(LANES)
) (
    input  xfer_size_e       size,
    input  logic [OFS_W-1:0] ofs,
    output logic [LANES-1:0] lanes,
    output logic             illegal
);
    localparam logic [LANES-1:0] ONE_LANE = LANES'(1);
    localparam logic [LANES-1:0] TWO_LANE = LANES'(3);
    localparam logic [OFS_W-1:0] TOP_OFS  = OFS_W'(LANES - 1);

    // Purpose: lane mask and legality from size and offset.
    always_comb begin
        lanes   = '0;
        illegal = 1'b0;
        case (size)
            SZ_BYTE: lanes = ONE_LANE << ofs;
            SZ_HALF: begin
                if (ofs == TOP_OFS) illegal = 1'b1;
                else                lanes   = TWO_LANE << ofs;
            end
            SZ_WORD: lanes = '1;
            default: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/lbw_req_hold.sv
// Holds the accepted request and its lane mask for the length of the pair.
// Assumes load is raised only for a legal request taken while idle.
// The reset value of the mask is all lanes, which is the value of the boot control write.
module lbw_req_hold
    import lbw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  xfer_size_e        in_size,
    input  logic [DATA_W-1:0] in_data,
    input  logic [LANES-1:0]  in_lanes,
    output logic [ADDR_W-1:0] q_addr,
    output xfer_size_e        q_size,
    output logic [DATA_W-1:0] q_data,
    output logic [LANES-1:0]  q_lanes
);
    // Purpose: capture the request on load; reset to an all-lane word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_size  <= SZ_WORD;
            q_data  <= '0;
            q_lanes <= '1;
        end else if (load) begin
            q_addr  <= in_addr;
            q_size  <= in_size;
            q_data  <= in_data;
            q_lanes <= in_lanes;
        end
    end
endmodule

// File: rtl/lbw_pair_fsm.sv
// Sequences boot control write, then control/data pairs per request.
// Assumes each acknowledge is raised only while its write is presented.
// Refused requests pulse an error and leave the phase at idle.
module lbw_pair_fsm
    import lbw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_illegal,
    input  logic ctl_ack,
    input  logic wr_ack,
    output logic req_ready,
    output logic load,
    output logic req_err,
    output logic ctl_valid,
    output logic wr_valid
);
    phase_e phase, phase_nx;
    logic   take;

    // Purpose: decode handshake and outputs from the phase.
    always_comb begin
        req_ready = (phase == PH_IDLE);
        take      = req_ready && req_valid;
        load      = take && !req_illegal;
        ctl_valid = (phase == PH_BOOT) || (phase == PH_CTL);
        wr_valid  = (phase == PH_DATA);
    end

    // Purpose: next phase from acknowledges and accepted requests.
    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_BOOT: if (ctl_ack) phase_nx = PH_IDLE;
            PH_IDLE: if (load)    phase_nx = PH_CTL;
            PH_CTL:  if (ctl_ack) phase_nx = PH_DATA;
            PH_DATA: if (wr_ack)  phase_nx = PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    // Purpose: phase register and registered error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_BOOT;
            req_err <= 1'b0;
        end else begin
            phase   <= phase_nx;
            req_err <= take && req_illegal;
        end
    end

    // R6: the data write never overlaps a control write
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_valid && wr_valid));

    // R6: the data write starts only right after a control acknowledge
    p_ctl_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> $past(ctl_valid && ctl_ack));

    // R7: ready returns the cycle after the data acknowledge
    p_ready_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ack) |=> req_ready);

    // R8: a refusal issues nothing and leaves the block idle
    p_err_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (req_ready && !ctl_valid && !wr_valid));
endmodule

// File: rtl/lbw_write_sequencer.sv
// Top of the byte-lane write sequencer: a control write carrying the lane
// nibble, then the data write, as one pair per accepted request.
// Assumes the requester holds req_* steady while req_valid waits for ready.
module lbw_write_sequencer
    import lbw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int CTL_W     = 32,
    parameter int CTL_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_err,
    output logic              ctl_valid,
    output logic [CTL_W-1:0]  ctl_data,
    input  logic              ctl_ack,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [1:0]        wr_size,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ack
);
    localparam int LANES = DATA_W / 8;
    localparam int OFS_W = $clog2(LANES);

    logic [LANES-1:0] dec_lanes, held_lanes;
    logic             dec_illegal, load;
    xfer_size_e       in_size, held_size;

    assign in_size = xfer_size_e'(req_size);

    lbw_lane_decode #(.LANES(LANES), .OFS_W(OFS_W)) u_decode (
        .size    (in_size),
        .ofs     (req_addr[OFS_W-1:0]),
        .lanes   (dec_lanes),
        .illegal (dec_illegal)
    );

    lbw_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .in_addr  (req_addr),
        .in_size  (in_size),
        .in_data  (req_data),
        .in_lanes (dec_lanes),
        .q_addr   (wr_addr),
        .q_size   (held_size),
        .q_data   (wr_data),
        .q_lanes  (held_lanes)
    );

    lbw_pair_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_illegal (dec_illegal),
        .ctl_ack     (ctl_ack),
        .wr_ack      (wr_ack),
        .req_ready   (req_ready),
        .load        (load),
        .req_err     (req_err),
        .ctl_valid   (ctl_valid),
        .wr_valid    (wr_valid)
    );

    // Purpose: place the held lane nibble at its field in the control word.
    always_comb begin
        ctl_data = CTL_W'(held_lanes) << CTL_SHIFT;
        wr_size  = held_size;
    end

    // R9: control write held until acknowledged
    p_ctl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && !ctl_ack) |=> (ctl_valid && $stable(ctl_data)));

    // R9: data write held until acknowledged
    p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ack) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R5: a word data write follows a control word enabling all lanes
    p_word_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_size == 2'd2) |-> (ctl_data[CTL_SHIFT +: LANES] == '1));
endmodule

// File: tb/lbw_write_sequencer_tb.sv
module lbw_write_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_data = '0;
    logic        req_err;
    logic        ctl_valid;
    logic [31:0] ctl_data;
    logic        ctl_ack = 1'b0;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [1:0]  wr_size;
    logic [31:0] wr_data;
    logic        wr_ack = 1'b0;

    lbw_write_sequencer u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_data(req_data), .req_err(req_err),
        .ctl_valid(ctl_valid), .ctl_data(ctl_data), .ctl_ack(ctl_ack),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_data(wr_data), .wr_ack(wr_ack)
    );

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    // request queues
    logic [31:0] q_addr[$];
    logic [1:0]  q_size[$];
    logic [31:0] q_data[$];
    bit          pend = 0;

    // behavioural reference: 0 boot, 1 idle, 2 control, 3 data
    int          m_phase = 0;
    logic [3:0]  m_lanes = 4'hF;
    logic [31:0] m_addr = 0, m_data = 0;
    logic [1:0]  m_size = 2;
    bit          m_err = 0;
    bit          first_cmp = 1;

    // byte-enabled target and expected memory
    logic [7:0]  dev_mem[64];
    logic [7:0]  exp_mem[64];
    logic [3:0]  dev_ctl = 4'h0;

    bit          prev_cw = 0, prev_dw = 0;
    logic [31:0] prev_cd = 0, prev_wa = 0, prev_wd = 0;
    int          idle_run = 0;
    bit          done = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [3:0] lanes_of(input logic [1:0] sz, input logic [1:0] ofs, output bit bad);
        bad = 0;
        case (sz)
            2'd0: return 4'b0001 << ofs;
            2'd1: begin
                if (ofs == 2'd3) begin bad = 1; return 4'h0; end
                return 4'b0011 << ofs;
            end
            2'd2: return 4'hF;
            default: begin bad = 1; return 4'h0; end
        endcase
    endfunction

    function automatic string lane_tag(input int ph, input logic [1:0] sz);
        if (ph == 0) return "R1";
        case (sz)
            2'd0: return "R3";
            2'd1: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic push(input logic [31:0] a, input logic [1:0] s, input logic [31:0] d);
        q_addr.push_back(a); q_size.push_back(s); q_data.push_back(d);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin dev_mem[i] = 8'h00; exp_mem[i] = 8'h00; end
        // bytes at each offset
        for (int o = 0; o < 4; o++) push(32'h10 + o, 2'd0, 32'hA1B2C3D4 + o);
        // halfwords at each offset (offset 3 refused)
        for (int o = 0; o < 4; o++) push(32'h20 + o, 2'd1, 32'h5566_7788 ^ o);
        push(32'h30, 2'd2, 32'hDEADBEEF);
        push(32'h34, 2'd3, 32'h01020304);
        push(32'h38, 2'd2, 32'hCAFEF00D);
        for (int i = 0; i < 80; i++)
            push({26'd0, 6'($urandom_range(0, 63))}, 2'($urandom_range(0, 3)), $urandom);
    end

    // compare, drive and advance the model, all between clock edges
    always @(negedge clk) begin
        bit bad;
        logic [3:0] ln;
        cyc++;
        if (cyc >= 2 && !done) begin
            check(req_ready == (m_phase == 1), "R7 ready", 32'(req_ready), 32'(m_phase == 1));
            check(ctl_valid == (m_phase == 0 || m_phase == 2), "R6 ctl_valid", 32'(ctl_valid), 32'(m_phase == 0 || m_phase == 2));
            check(wr_valid == (m_phase == 3), "R6 wr_valid", 32'(wr_valid), 32'(m_phase == 3));
            check(req_err == m_err, "R8 err", 32'(req_err), 32'(m_err));
            if (first_cmp && rst_n) begin
                check(ctl_valid && !req_ready && ctl_data == 32'h78, "R1 boot", ctl_data, 32'h78);
                first_cmp = 0;
            end
            if (ctl_valid) begin
                check(ctl_data == {25'd0, m_lanes, 3'd0}, lane_tag(m_phase, m_size), ctl_data, {25'd0, m_lanes, 3'd0});
                check((ctl_data & ~32'h78) == 0, "R2 field", ctl_data, ctl_data & 32'h78);
            end
            if (wr_valid) begin
                check(wr_addr == m_addr && wr_data == m_data && wr_size == m_size, "R10 payload", wr_data, m_data);
            end
            if (prev_cw) check(ctl_valid && ctl_data == prev_cd, "R9 ctl hold", ctl_data, prev_cd);
            if (prev_dw) check(wr_valid && wr_addr == prev_wa && wr_data == prev_wd, "R9 wr hold", wr_data, prev_wd);
        end

        if (cyc == 4) rst_n = 1'b1;
        if (cyc > 50000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            done = 1;
        end

        // drive inputs for the coming edge
        if (!pend && q_addr.size() > 0 && rst_n && m_phase == 1 && ($urandom_range(0, 3) != 0)) begin
            req_addr = q_addr.pop_front();
            req_size = q_size.pop_front();
            req_data = q_data.pop_front();
            pend = 1;
        end
        req_valid = pend;
        ctl_ack = rst_n && (m_phase == 0 || m_phase == 2) && ($urandom_range(0, 2) == 0);
        wr_ack  = rst_n && (m_phase == 3) && ($urandom_range(0, 2) == 0);

        prev_cw = rst_n && ctl_valid && !ctl_ack;
        prev_dw = rst_n && wr_valid && !wr_ack;
        prev_cd = ctl_data; prev_wa = wr_addr; prev_wd = wr_data;

        // target side effects at the coming edge
        if (ctl_ack && ctl_valid) dev_ctl = ctl_data[6:3];
        if (wr_ack && wr_valid)
            for (int l = 0; l < 4; l++)
                if (dev_ctl[l]) dev_mem[{wr_addr[5:2], 2'(l)}] = wr_data[8*l +: 8];

        // advance the reference
        m_err = 0;
        if (!rst_n) begin
            m_phase = 0; m_lanes = 4'hF; m_addr = 0; m_data = 0; m_size = 2;
        end else begin
            case (m_phase)
                0: if (ctl_ack) m_phase = 1;
                1: if (req_valid) begin
                    ln = lanes_of(req_size, req_addr[1:0], bad);
                    pend = 0;
                    if (bad) m_err = 1;
                    else begin
                        m_lanes = ln; m_addr = req_addr; m_data = req_data; m_size = req_size;
                        m_phase = 2;
                        for (int l = 0; l < 4; l++)
                            if (ln[l]) exp_mem[{req_addr[5:2], 2'(l)}] = req_data[8*l +: 8];
                    end
                end
                2: if (ctl_ack) m_phase = 3;
                default: if (wr_ack) m_phase = 1;
            endcase
        end

        if (!done && rst_n && q_addr.size() == 0 && !pend && m_phase == 1) idle_run++;
        else idle_run = 0;
        if (idle_run == 6 && !done) begin
            for (int i = 0; i < 64; i++)
                check(dev_mem[i] == exp_mem[i], "R10 memory", 32'(dev_mem[i]), 32'(exp_mem[i]));
            done = 1;
        end
        if (done) begin
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule